// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a memory read port and an instruction consumer. It produces its own fetch addresses, one byte per request, and keeps reading ahead into a small byte queue while the queue has room. The consumer takes bytes from the head of the queue on its own schedule. Filling and draining proceed in the same cycle without interfering, so memory latency is hidden whenever the consumer is slower than the bus.

When the consumer takes a branch, it raises `flush` for one cycle with the new target on `flush_addr`. Every byte held in the queue is thrown away. Any read still in flight is marked dead, and its response is dropped when it comes back. The next request goes out to the target address. Until the first byte from the target arrives, the consumer sees no valid byte.

Reads complete in request order, one response per accepted request. A request is issued only when the free slots in the queue outnumber the reads in flight, so a response always has a slot to land in. A full queue leaves the memory port idle.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty (`pop_valid` low) and, with `flush` low, a request is offered at address `RESET_ADDR` (zero by default).
- R2: Each request accepted (`req_valid` and `req_ready` both high) advances `req_addr` by one, wrapping modulo 2^ADDR_W. A request offered but not accepted keeps the same address.
- R3: `req_valid` is high exactly when `flush` is low, fewer than MAX_OUT reads are in flight, and the free slots (DEPTH minus bytes held) exceed the reads in flight. A full queue therefore keeps the port idle.
- R4: Bytes leave in the order their live responses arrived. `pop_valid` is high exactly when the queue holds a byte, and `pop_data` is the oldest byte. A response taken at one clock edge can be popped from the next cycle on.
- R5: A pop and a live response in the same cycle both take effect: the head byte leaves and the new byte is appended.
- R6: A cycle with `flush` high empties the queue, so `pop_valid` is low in the following cycle, and offers no request in that cycle.
- R7: The first request after a flush carries the `flush_addr` value sampled in the flush cycle.
- R8: A response to a read that was in flight during a flush is discarded and never reaches the queue.
- R9: A flush takes precedence over a pop and over a response arriving in the same cycle. Neither of them alters the emptied queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Branch redirect strobe |
| flush_addr | input | ADDR_W | Redirect target address |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address of the request |
| rsp_valid | input | 1 | Read response present (in request order) |
| rsp_data | input | DATA_W | Response byte |
| pop_valid | output | 1 | Queue head holds a byte |
| pop_ready | input | 1 | Consumer takes the head byte |
| pop_data | output | DATA_W | Head byte |

## Verification
The hardest coincidence is a flush landing in the same cycle as a returning response and a consumer pop. In that cycle the redirect must win over both, and any dead response still to come must not leak into the refilled queue. Directed sequences provoke this by flushing while two reads are outstanding and data is queued with `pop_ready` high. Random runs repeat it with a few percent flush probability against random memory latency and random back-pressure. A bench scoreboard marks in-flight reads dead on each flush and predicts the head byte, `pop_valid` and the next fetch address every cycle. A pop coinciding with a push is judged by the byte order seen at later pops.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int cnt_w(input int v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
   parameter int DEPTH  = 6,
   parameter int DATA_W = 8,
   localparam int CW    = pfq_pkg::cnt_w(DEPTH),
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic [CW-1:0]     count,
   output logic [CW-1:0]     free_slots
);

   logic [PW-1:0]           rd_q, wr_q, rd_inc, wr_inc;
   logic [CW-1:0]           cnt_q;
   logic [DEPTH*DATA_W-1:0] flat;

   // pointer wrap: free for power-of-two depths, compare otherwise
   generate
      if (pfq_pkg::is_pow2(DEPTH)) begin : g_pow2
         assign rd_inc = rd_q + 1'b1;
         assign wr_inc = wr_q + 1'b1;
      end else begin : g_wrap
         assign rd_inc = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
         assign wr_inc = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_inc;
         if (pop)  rd_q <= rd_inc;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= '0;
         else if (push && !clear && wr_q == PW'(i))   q <= push_data;
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   assign head_data  = flat[int'(rd_q)*DATA_W +: DATA_W];
   assign count      = cnt_q;
   assign free_slots = CW'(DEPTH) - cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clear) |-> (cnt_q != CW'(DEPTH))); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clear) |-> (cnt_q != '0)); // R4
   AST_PUSH_POP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !clear) |=> $stable(cnt_q)); // R5
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pfq_track.sv
module pfq_track #(
   parameter int MAX_OUT = 2,
   localparam int NW     = pfq_pkg::cnt_w(MAX_OUT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          retire,
   input  logic          drop_all,
   output logic [NW-1:0] outstanding,
   output logic          head_live
);

   // one live bit per read in flight, oldest in bit 0
   logic [MAX_OUT-1:0] live_q, live_d;
   logic [NW-1:0]      n_q, n_d, slot_idx;

   always_comb begin
      slot_idx = n_q - NW'(retire);
      live_d   = retire ? (live_q >> 1) : live_q;
      if (drop_all) live_d = '0;
      for (int k = 0; k < MAX_OUT; k++) begin
         if (issue && int'(slot_idx) == k) live_d[k] = 1'b1;
      end
      n_d = n_q + NW'(issue) - NW'(retire);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         n_q    <= '0;
      end else begin
         live_q <= live_d;
         n_q    <= n_d;
      end
   end

   assign outstanding = n_q;
   assign head_live   = live_q[0];

   AST_NO_ISSUE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (int'(n_q) < MAX_OUT)); // R3
   AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (n_q != '0)); // R8
   AST_DROP_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_all && !issue) |=> (live_q == '0)); // R8

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
   parameter int ADDR_W                  = 16,
   parameter int DEPTH                   = 6,
   parameter int MAX_OUT                 = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   localparam int CW                     = pfq_pkg::cnt_w(DEPTH),
   localparam int NW                     = pfq_pkg::cnt_w(MAX_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic [CW-1:0]     free_slots,
   input  logic [NW-1:0]     outstanding,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic              accept
);

   logic [ADDR_W-1:0] addr_q;

   assign req_valid = !flush
                      && (int'(outstanding) < MAX_OUT)
                      && (int'(free_slots) > int'(outstanding));
   assign accept    = req_valid && req_ready;
   assign req_addr  = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= RESET_ADDR;
      else if (flush)  addr_q <= flush_addr;
      else if (accept) addr_q <= addr_q + 1'b1;
   end

   AST_ADDR_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (req_addr == $past(flush_addr))); // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(req_addr)); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (req_addr == $past(req_addr) + 1'b1)); // R2
   AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (free_slots == '0) |-> !req_valid); // R3

endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
   parameter int ADDR_W                    = 16,
   parameter int DATA_W                    = 8,
   parameter int DEPTH                     = 6,
   parameter int MAX_OUT                   = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              pop_valid,
   input  logic              pop_ready,
   output logic [DATA_W-1:0] pop_data
);

   localparam int CW = pfq_pkg::cnt_w(DEPTH);
   localparam int NW = pfq_pkg::cnt_w(MAX_OUT);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pfq_top: DEPTH must be at least 2");
      end
      if (MAX_OUT < 1 || MAX_OUT > DEPTH) begin : g_bad_out
         $error("pfq_top: MAX_OUT must lie in 1..DEPTH");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("pfq_top: widths must be positive");
      end
   endgenerate

   logic [CW-1:0] q_count, free_slots;
   logic [NW-1:0] outstanding;
   logic          head_live, accept, do_push, do_pop;

   // flush overrides both queue operations in its cycle
   assign do_push   = rsp_valid && head_live && !flush;
   assign do_pop    = pop_ready && pop_valid && !flush;
   assign pop_valid = (q_count != '0);

   pfq_fetch #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .RESET_ADDR(RESET_ADDR)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .free_slots(free_slots), .outstanding(outstanding), .req_ready(req_ready),
      .req_valid(req_valid), .req_addr(req_addr), .accept(accept)
   );

   pfq_track #(.MAX_OUT(MAX_OUT)) u_track (
      .clk(clk), .rst_n(rst_n), .issue(accept), .retire(rsp_valid),
      .drop_all(flush), .outstanding(outstanding), .head_live(head_live)
   );

   pfq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(flush), .push(do_push), .push_data(rsp_data),
      .pop(do_pop), .head_data(pop_data), .count(q_count), .free_slots(free_slots)
   );

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pop_valid); // R6
   AST_NO_REQ_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !flush); // R6
   AST_FILL_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && !flush) |=> pop_valid); // R4

endmodule

// File: tb/pfq_top_tb.sv
`timescale 1ns/1ps
module pfq_top_tb;

   localparam int DEPTH   = 6;
   localparam int MAX_OUT = 2;
   localparam int AW      = 16;
   localparam int DW      = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush, req_ready, rsp_valid, pop_ready;
   logic [AW-1:0] flush_addr, req_addr;
   logic [DW-1:0] rsp_data, pop_data;
   logic          req_valid, pop_valid;

   always #2.5 clk = ~clk;

   pfq_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data)
   );

   int  total = 0;
   int  bad   = 0;
   bit  done  = 0;

   logic [DW-1:0] expq[$];
   logic [AW-1:0] pend_a[$];
   bit            pend_l[$];
   logic [AW-1:0] exp_addr;

   function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic bit rnd(input int pct);
      return (int'($urandom_range(99)) < pct);
   endfunction

   function automatic bit room();
      return (pend_a.size() < MAX_OUT) && ((DEPTH - expq.size()) > pend_a.size());
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // mode 1: queue must be full and the port idle; mode 2: queue must be empty
   task automatic step(input bit fl, input logic [AW-1:0] fa, input int p_pop,
                       input int p_rdy, input int p_rsp, input int mode);
      bit rsp_live;
      bit popped;
      @(negedge clk);
      flush      = fl;
      flush_addr = fa;
      pop_ready  = rnd(p_pop);
      req_ready  = rnd(p_rdy);
      rsp_valid  = (pend_a.size() > 0) && rnd(p_rsp);
      rsp_data   = rsp_valid ? mem_byte(pend_a[0]) : '0;
      #1;
      chk(pop_valid == (expq.size() != 0), "R4,R8 pop_valid", int'(pop_valid), int'(expq.size() != 0));
      if (pop_valid && expq.size() > 0)
         chk(pop_data == expq[0], "R4,R5 pop_data", int'(pop_data), int'(expq[0]));
      if (req_valid) begin
         chk(!fl, "R6 request during flush", int'(fl), 0);
         chk(room(), "R3 issue without room", pend_a.size(), DEPTH - expq.size());
         chk(req_addr == exp_addr, "R2,R7 fetch address", int'(req_addr), int'(exp_addr));
      end else begin
         chk(fl || !room(), "R3 idle despite room", int'(req_valid), 1);
      end
      if (mode == 1)
         chk(!req_valid && expq.size() == DEPTH, "R3 full queue idles port", int'(req_valid), 0);
      if (mode == 2)
         chk(!pop_valid, "R6,R9 empty after flush", int'(pop_valid), 0);

      rsp_live = 1'b0;
      if (rsp_valid) begin
         rsp_live = pend_l[0];
         void'(pend_a.pop_front());
         void'(pend_l.pop_front());
      end
      popped = pop_valid && pop_ready;
      if (fl) begin
         expq.delete();
         foreach (pend_l[i]) pend_l[i] = 1'b0;
         exp_addr = fa;
      end else begin
         if (popped)   void'(expq.pop_front());
         if (rsp_live) expq.push_back(rsp_data);
         if (req_valid && req_ready) begin
            pend_a.push_back(req_addr);
            pend_l.push_back(1'b1);
            exp_addr = exp_addr + 1'b1;
         end
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7351));
      flush = 0; flush_addr = '0; pop_ready = 0; req_ready = 0;
      rsp_valid = 0; rsp_data = '0; exp_addr = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!pop_valid, "R1 reset pop_valid", int'(pop_valid), 0);
      chk(req_valid, "R1 reset req_valid", int'(req_valid), 1);
      chk(req_addr == '0, "R1 reset address", int'(req_addr), 0);

      // fill with no consumer until the port goes idle
      repeat (24) step(0, '0, 0, 100, 100, 0);
      step(0, '0, 0, 100, 100, 1);

      // two reads in flight, then redirect: their data must vanish
      step(1, 16'h1000, 0, 0, 0, 0);
      step(0, '0, 0, 100, 0, 0);
      step(0, '0, 0, 100, 0, 0);
      step(1, 16'h2000, 0, 0, 0, 0);
      repeat (5) step(0, '0, 0, 0, 100, 2);
      repeat (10) step(0, '0, 50, 100, 100, 0);

      // flush together with a pop and a returning byte
      repeat (6) step(0, '0, 0, 100, 100, 0);
      step(1, 16'hFFFE, 100, 100, 100, 0);
      step(0, '0, 0, 0, 0, 2);
      repeat (8) step(0, '0, 30, 100, 100, 0);

      // random traffic
      for (int n = 0; n < 4000; n++)
         step(rnd(3), AW'($urandom), 60, 70, 50, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule